// File: doc/BRIEF.md
# Four-Bit Arithmetic-Logic Unit with Single-Bit Shifts

The block is a purely combinational arithmetic-logic unit for narrow operands. A 4-bit opcode selects one of sixteen operations on two operands `a_in` and `b_in`. The operations fall into five groups: pass-through and bitwise logic, two's-complement add and subtract, add and subtract that take an incoming carry or borrow, increment of the second operand, and one-place shifts of the first operand. An opcode that clears the result is also provided. Four status flags accompany the result: sign, zero, carry/borrow-out and signed overflow. Each operation group has its own rule for these flags.

Chained arithmetic on operands wider than four bits works as follows. The surrounding logic holds the carry or borrow of the previous slice and returns it on `carry_in` (for add-with-carry) or on `borrow_in` (for subtract-with-borrow). The unit stores no flags. The operand width is a parameter with a default of 4. The ripple adder or an inferred adder is chosen at elaboration.

Top module: `alu4_core`

## Requirements
- R1: Opcodes 0000, 0001, 0010, 0011, 0100 and 0111 give A, NOT A, A AND B, A OR B, A XOR B and B respectively.
- R2: Opcode 0101 gives (A+B) mod 16 and opcode 0110 gives (A−B) mod 16. Neither uses `carry_in` or `borrow_in`.
- R3: Opcode 1101 gives (A+B+`carry_in`) mod 16, with COUT set when the unsigned sum exceeds 15. Opcode 1110 gives (A−B−`borrow_in`) mod 16, with COUT set when A < B+`borrow_in` (unsigned).
- R4: Opcode 1111 gives (B+1) mod 16. COUT is set only for B=1111, and OVF is set only for B=0111.
- R5: Opcodes 1000 and 1010 shift A left one place and fill bit 0 with 0. Opcode 1001 shifts right and fills bit 3 with 0. Opcode 1011 shifts right and fills bit 3 with the old A[3].
- R6: On every shift opcode, COUT equals the bit moved out: A[3] for 1000 and 1010, A[0] for 1001 and 1011.
- R7: OVF is 0 for opcodes 1000, 1001 and 1011. OVF equals A[3] XOR A[2] for opcode 1010.
- R8: Opcode 1100 gives result 0000 with S=0, Z=1, COUT=0 and OVF=0.
- R9: For every opcode, S equals result bit 3, and Z is 1 exactly when the result is 0000.
- R10: On opcodes 0101 and 1101, OVF is set when both operands share a sign and the result sign differs. On opcodes 0110 and 1110, OVF is set when A and B differ in sign and the result sign differs from A's. On opcodes 0101 and 0110, COUT is the carry and the borrow respectively.
- R11: On opcodes 0000 to 0100 and 0111, COUT and OVF are 0.
- R12: `carry_in` affects only opcode 1101, and `borrow_in` affects only opcode 1110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | First operand; the shift source |
| b_in | input | WIDTH | Second operand |
| op_in | input | 4 | Operation code |
| carry_in | input | 1 | Carry kept from an earlier add |
| borrow_in | input | 1 | Borrow kept from an earlier subtract |
| result_out | output | WIDTH | Operation result |
| sign_out | output | 1 | Sign flag |
| zero_out | output | 1 | Zero flag |
| cout_out | output | 1 | Carry-out, borrow-out, or shifted-out bit |
| ovf_out | output | 1 | Signed overflow flag |

## Verification
The bound checker evaluates several rules whenever the inputs change. These are the shift fill bit and shifted-out bit, the zero overflow of the logical shifts and of arithmetic right shift, the fixed outputs of the clear opcode, the quiet COUT and OVF of the logic group, and the consistency of S and Z with the result. The exact arithmetic values need the bench's exhaustive sweep against an integer reference model. This covers add and subtract modulo 16, the borrow compare, the signed-overflow boundaries and the B=0111 increment case. The same sweep shows that `carry_in` and `borrow_in` have no effect on the opcodes that must ignore them.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

   localparam int unsigned OPW = 4;

   typedef enum logic [OPW-1:0] {
      OP_PASS_A = 4'b0000,
      OP_NOT_A  = 4'b0001,
      OP_AND    = 4'b0010,
      OP_OR     = 4'b0011,
      OP_XOR    = 4'b0100,
      OP_ADD    = 4'b0101,
      OP_SUB    = 4'b0110,
      OP_PASS_B = 4'b0111,
      OP_LSL    = 4'b1000,
      OP_LSR    = 4'b1001,
      OP_ASL    = 4'b1010,
      OP_ASR    = 4'b1011,
      OP_CLEAR  = 4'b1100,
      OP_ADDC   = 4'b1101,
      OP_SUBB   = 4'b1110,
      OP_INCB   = 4'b1111
   } alu_op_e;

   typedef enum logic [1:0] {
      CLS_LOGIC = 2'd0,
      CLS_ARITH = 2'd1,
      CLS_SHIFT = 2'd2,
      CLS_CLEAR = 2'd3
   } alu_cls_e;

   function automatic alu_cls_e op_class(input logic [OPW-1:0] op);
      alu_cls_e c;
      case (op)
         OP_ADD, OP_SUB, OP_ADDC, OP_SUBB, OP_INCB: c = CLS_ARITH;
         OP_LSL, OP_LSR, OP_ASL, OP_ASR:            c = CLS_SHIFT;
         OP_CLEAR:                                  c = CLS_CLEAR;
         default:                                   c = CLS_LOGIC;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [OPW-1:0]   op,
   output logic [WIDTH-1:0] res
);

   always_comb begin
      case (op)
         OP_PASS_A: res = a;
         OP_NOT_A:  res = ~a;
         OP_AND:    res = a & b;
         OP_OR:     res = a | b;
         OP_XOR:    res = a ^ b;
         OP_PASS_B: res = b;
         default:   res = '0;
      endcase
   end

endmodule

// File: rtl/alu4_arith_unit.sv
module alu4_arith_unit
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH        = 4,
   parameter bit          RIPPLE_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [OPW-1:0]   op,
   input  logic             carry_in,
   input  logic             borrow_in,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);

   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] opx, opy;
   logic             cin, is_sub, carry;

   // operand steering: subtract is a + ~b + (1 - borrow), increment is b + 0 + 1
   always_comb begin
      opx    = a;
      opy    = b;
      cin    = 1'b0;
      is_sub = 1'b0;
      case (op)
         OP_ADD:  begin opy = b;  cin = 1'b0;       end
         OP_ADDC: begin opy = b;  cin = carry_in;   end
         OP_SUB:  begin opy = ~b; cin = 1'b1;       is_sub = 1'b1; end
         OP_SUBB: begin opy = ~b; cin = ~borrow_in; is_sub = 1'b1; end
         OP_INCB: begin opx = b;  opy = '0; cin = 1'b1; end
         default: begin opx = a;  opy = b;  cin = 1'b0; end
      endcase
   end

   generate
      if (RIPPLE_ADDER) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < WIDTH; i++) begin : g_fa
            assign sum[i]   = opx[i] ^ opy[i] ^ cy[i];
            assign cy[i+1]  = (opx[i] & opy[i]) | (cy[i] & (opx[i] ^ opy[i]));
         end
         assign carry = cy[WIDTH];
      end else begin : g_inferred
         logic [WIDTH:0] wide;
         assign wide  = {1'b0, opx} + {1'b0, opy} + {{WIDTH{1'b0}}, cin};
         assign sum   = wide[WIDTH-1:0];
         assign carry = wide[WIDTH];
      end
   endgenerate

   // borrow is the inverse of the carry of the complemented addition
   assign cout = is_sub ? ~carry : carry;
   assign ovf  = (opx[MSB] == opy[MSB]) && (sum[MSB] != opx[MSB]);

endmodule

// File: rtl/alu4_shift_unit.sv
module alu4_shift_unit
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] a,
   input  logic [OPW-1:0]   op,
   output logic [WIDTH-1:0] res,
   output logic             cout,
   output logic             ovf
);

   localparam int unsigned MSB = WIDTH - 1;

   logic [WIDTH-1:0] left_v, right_v;
   logic             right_fill;

   assign right_fill = (op == OP_ASR) ? a[MSB] : 1'b0;
   assign left_v     = {a[MSB-1:0], 1'b0};
   assign right_v    = {right_fill, a[MSB:1]};

   always_comb begin
      case (op)
         OP_LSL:  begin res = left_v;  cout = a[MSB]; ovf = 1'b0; end
         OP_ASL:  begin res = left_v;  cout = a[MSB]; ovf = a[MSB] ^ a[MSB-1]; end
         OP_LSR:  begin res = right_v; cout = a[0];   ovf = 1'b0; end
         OP_ASR:  begin res = right_v; cout = a[0];   ovf = 1'b0; end
         default: begin res = '0;      cout = 1'b0;   ovf = 1'b0; end
      endcase
   end

endmodule

// File: rtl/alu4_flag_unit.sv
module alu4_flag_unit
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] result,
   input  alu_cls_e         cls,
   input  logic             arith_cout,
   input  logic             arith_ovf,
   input  logic             shift_cout,
   input  logic             shift_ovf,
   output logic             sign,
   output logic             zero,
   output logic             cout,
   output logic             ovf
);

   always_comb begin
      sign = result[WIDTH-1];
      zero = ~|result;
      case (cls)
         CLS_ARITH: begin cout = arith_cout; ovf = arith_ovf; end
         CLS_SHIFT: begin cout = shift_cout; ovf = shift_ovf; end
         CLS_CLEAR: begin cout = 1'b0; ovf = 1'b0; sign = 1'b0; zero = 1'b1; end
         default:   begin cout = 1'b0; ovf = 1'b0; end
      endcase
   end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
   import alu4_pkg::*;
#(
   parameter int unsigned WIDTH        = 4,
   parameter bit          RIPPLE_ADDER = 1'b1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [3:0]       op_in,
   input  logic             carry_in,
   input  logic             borrow_in,
   output logic [WIDTH-1:0] result_out,
   output logic             sign_out,
   output logic             zero_out,
   output logic             cout_out,
   output logic             ovf_out
);

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu4_core: WIDTH must be at least 2");
      end
   endgenerate

   alu_cls_e         cls;
   logic [WIDTH-1:0] logic_res, arith_res, shift_res;
   logic             arith_cout, arith_ovf, shift_cout, shift_ovf;

   assign cls = op_class(op_in);

   alu4_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .a(a_in), .b(b_in), .op(op_in), .res(logic_res)
   );

   alu4_arith_unit #(.WIDTH(WIDTH), .RIPPLE_ADDER(RIPPLE_ADDER)) u_arith (
      .a(a_in), .b(b_in), .op(op_in),
      .carry_in(carry_in), .borrow_in(borrow_in),
      .sum(arith_res), .cout(arith_cout), .ovf(arith_ovf)
   );

   alu4_shift_unit #(.WIDTH(WIDTH)) u_shift (
      .a(a_in), .op(op_in),
      .res(shift_res), .cout(shift_cout), .ovf(shift_ovf)
   );

   always_comb begin
      case (cls)
         CLS_ARITH: result_out = arith_res;
         CLS_SHIFT: result_out = shift_res;
         CLS_CLEAR: result_out = '0;
         default:   result_out = logic_res;
      endcase
   end

   alu4_flag_unit #(.WIDTH(WIDTH)) u_flags (
      .result(result_out), .cls(cls),
      .arith_cout(arith_cout), .arith_ovf(arith_ovf),
      .shift_cout(shift_cout), .shift_ovf(shift_ovf),
      .sign(sign_out), .zero(zero_out), .cout(cout_out), .ovf(ovf_out)
   );

endmodule

// File: rtl/alu4_core_checker.sv
module alu4_core_checker #(
   parameter int unsigned WIDTH = 4
) (
   input logic [WIDTH-1:0] a_in,
   input logic [WIDTH-1:0] b_in,
   input logic [3:0]       op_in,
   input logic             carry_in,
   input logic             borrow_in,
   input logic [WIDTH-1:0] result_out,
   input logic             sign_out,
   input logic             zero_out,
   input logic             cout_out,
   input logic             ovf_out
);

   localparam int unsigned MSB = WIDTH - 1;

   always_comb begin
      if (!$isunknown({a_in, b_in, op_in, carry_in, borrow_in})) begin
         // R5: arithmetic right shift keeps the sign bit in place
         if (op_in == 4'b1011)
            a_r5_asr_sign_fill: assert (result_out[MSB] == a_in[MSB]);
         // R5: logical right shift fills with zero
         if (op_in == 4'b1001)
            a_r5_lsr_zero_fill: assert (result_out[MSB] == 1'b0);
         // R6: shifted-out bit on carry
         if (op_in == 4'b1000 || op_in == 4'b1010)
            a_r6_left_out_bit: assert (cout_out == a_in[MSB]);
         if (op_in == 4'b1001 || op_in == 4'b1011)
            a_r6_right_out_bit: assert (cout_out == a_in[0]);
         // R7: no overflow for logical shifts and arithmetic right shift
         if (op_in == 4'b1000 || op_in == 4'b1001 || op_in == 4'b1011)
            a_r7_no_overflow: assert (ovf_out == 1'b0);
         // R8: clear opcode
         if (op_in == 4'b1100)
            a_r8_clear_outputs: assert (result_out == '0 && !sign_out && zero_out
                                        && !cout_out && !ovf_out);
         // R9: flags consistent with result
         a_r9_sign_zero: assert (sign_out == result_out[MSB]
                                 && zero_out == (result_out == '0));
         // R11: quiet flags for logic group
         if (op_in <= 4'b0100 || op_in == 4'b0111)
            a_r11_logic_quiet: assert (!cout_out && !ovf_out);
      end
   end

endmodule

bind alu4_core alu4_core_checker #(.WIDTH(WIDTH)) u_alu4_chk (
   .a_in(a_in), .b_in(b_in), .op_in(op_in),
   .carry_in(carry_in), .borrow_in(borrow_in),
   .result_out(result_out), .sign_out(sign_out), .zero_out(zero_out),
   .cout_out(cout_out), .ovf_out(ovf_out)
);

// File: tb/alu4_core_test.sv
module alu4_core_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] a, b, op;
   logic       ci, bi;
   logic [3:0] f;
   logic       s, z, co, ov;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   alu4_core uut (
      .a_in(a), .b_in(b), .op_in(op), .carry_in(ci), .borrow_in(bi),
      .result_out(f), .sign_out(s), .zero_out(z), .cout_out(co), .ovf_out(ov)
   );

   task automatic check(input string tag, input int got, input int exp,
                        input string what);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s op=%b a=%b b=%b ci=%0b bi=%0b: actual=%0d expected=%0d",
                  tag, what, op, a, b, ci, bi, got, exp);
      end
   endtask

   function automatic int sx(input int v);
      return (v >= 8) ? v - 16 : v;
   endfunction

   // reference model computed with integers from the requirements
   task automatic model(input int o, input int av, input int bv, input int c,
                        input int w, output int ef, output int ec, output int eo);
      int t, st;
      ec = 0; eo = 0; ef = 0;
      case (o)
         0: ef = av;
         1: ef = 15 - av;
         2: ef = av & bv;
         3: ef = av | bv;
         4: ef = av ^ bv;
         7: ef = bv;
         5, 13: begin
            t  = av + bv + ((o == 13) ? c : 0);
            st = sx(av) + sx(bv) + ((o == 13) ? c : 0);
            ef = t % 16; ec = (t > 15); eo = (st > 7 || st < -8);
         end
         6, 14: begin
            t  = av - bv - ((o == 14) ? w : 0);
            st = sx(av) - sx(bv) - ((o == 14) ? w : 0);
            ef = (t + 32) % 16; ec = (t < 0); eo = (st > 7 || st < -8);
         end
         15: begin
            t = bv + 1; st = sx(bv) + 1;
            ef = t % 16; ec = (t > 15); eo = (st > 7);
         end
         8, 10: begin
            ef = (av * 2) % 16; ec = av / 8;
            st = sx(av) * 2;
            eo = (o == 10) ? int'(st > 7 || st < -8) : 0;
         end
         9:  begin ef = av / 2; ec = av % 2; end
         11: begin ef = av / 2 + ((av >= 8) ? 8 : 0); ec = av % 2; end
         default: begin ef = 0; ec = 0; eo = 0; end
      endcase
   endtask

   function automatic string res_tag(input int o, input int c, input int w);
      if (o <= 4 || o == 7)      return "R1";
      if (o == 5 || o == 6)      return (c == 1 || w == 1) ? "R12" : "R2";
      if (o == 13 || o == 14)    return "R3";
      if (o == 15)               return "R4";
      if (o == 12)               return "R8";
      return "R5";
   endfunction

   function automatic string flag_tag(input int o);
      if (o <= 4 || o == 7)      return "R11";
      if (o == 5 || o == 6)      return "R10";
      if (o == 13 || o == 14)    return "R3";
      if (o == 15)               return "R4";
      if (o == 12)               return "R8";
      return "R6";
   endfunction

   function automatic string ovf_tag(input int o);
      if (o >= 8 && o <= 11)     return "R7";
      if (o == 13 || o == 14)    return "R10";
      return flag_tag(o);
   endfunction

   initial begin
      int ef, ec, eo;
      a = '0; b = '0; op = '0; ci = 1'b0; bi = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: zero inputs on opcode 0000 give a zero result
      check("R1", int'(f), 0, "reset result");
      check("R9", int'(z), 1, "reset zero flag");
      rst = 1'b0;
      // R12: both carry_in and borrow_in values are swept for every opcode
      for (int o = 0; o < 16; o++) begin
         for (int cw = 0; cw < 2; cw++) begin
            for (int av = 0; av < 16; av++) begin
               for (int bv = 0; bv < 16; bv++) begin
                  @(posedge clk);
                  op = 4'(o); a = 4'(av); b = 4'(bv);
                  ci = cw[0]; bi = cw[0];
                  model(o, av, bv, cw, cw, ef, ec, eo);
                  @(negedge clk);
                  check(res_tag(o, cw, cw), int'(f), ef, "result");
                  check(flag_tag(o), int'(co), ec, "cout");
                  check(ovf_tag(o), int'(ov), eo, "ovf");
                  if (o != 12) begin
                     check("R9", int'(s), ef / 8, "sign");
                     check("R9", int'(z), int'(ef == 0), "zero");
                  end else begin
                     check("R8", int'(s), 0, "sign");
                     check("R8", int'(z), 1, "zero");
                  end
               end
            end
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule